// File: doc/BRIEF.md
# PCI Memory Window Address Translator

This block maps CPU accesses that land in one of three fixed-size system windows onto addresses in a 32-bit PCI memory space. Each window has a programmable mapping register that supplies the upper address bits. The low part of the PCI address is the offset of the access inside its window.

Two translation rules are available, selected by a strap input. The nibble rule places the low four bits of the mapping register at PCI address bits 31:28. The masked rule keeps the bits of the mapping register above the window's power-of-two size and clears the bits below it. Each rule has its own set of three window sizes. The windows are tested in index order, and an offset past the end of the selected window reports a miss.

A small 32-bit register port holds the three mapping registers. It also holds three slave-map words, an identity word and a miscellaneous word, which are plain storage. An access that is not a full aligned word, or that targets an unassigned offset, raises a one-cycle error pulse and changes nothing.

Top module: `pcimem_xlate`

## Requirements
- R1: Synchronous reset clears every register to zero, drives pci_valid, pci_miss, reg_err and reg_rdata to zero, and leaves every window base at zero, so a hit translates to its bare offset under either rule.
- R2: With rule_sel=0 (nibble rule), a window hit translates to {map[3:0], 28'h0} + offset. The window sizes for this rule are 0x0C000000, 0x10000000 and 0x10000000 for windows 0, 1 and 2.
- R3: With rule_sel=1 (masked rule), a window hit translates to (map & ~(size-1)) + offset. The window sizes for this rule are 0x01000000, 0x04000000 and 0x08000000 for windows 0, 1 and 2.
- R4: An offset that is greater than or equal to the size of the selected window gives pci_miss=1, pci_valid=0 and pci_addr=0. pci_valid and pci_miss are never high together.
- R5: Register offsets are as follows. The mapping registers sit at 0x00, 0x04 and 0x08, so window index = offset>>2. The slave-map words sit at 0x10, 0x14 and 0x18, the identity word at 0x20 and the miscellaneous word at 0x24. A read returns the full stored 32-bit value on reg_rdata in the cycle after the access, with reg_err=0.
- R6: An access with reg_be other than 4'hF, with a nonzero reg_addr[1:0], or to any other offset (for example 0x0C) pulses reg_err for one cycle. Such an access changes no register, and such a read returns zero.
- R7: The translation result is registered: a hit presented in cycle k shows on the outputs in cycle k+1. A mapping-register write or a rule change reaches the window base one cycle after it is stored. A hit sampled at the write's own clock edge, or at the edge after it, therefore uses the old base. A hit sampled at the second edge or later uses the new base.
- R8: When several win_hit bits are set, the lowest-index window alone decides the result, including a miss. When no bit is set, pci_valid=0 and pci_miss=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_sel | input | 1 | Translation rule: 0 nibble, 1 masked |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 4 | Byte enables; only 4'hF is legal |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_err | output | 1 | One-cycle error pulse for an illegal access |
| win_hit | input | 3 | Per-window hit strobes |
| win_off | input | 28 | Offset of the access within its window |
| pci_valid | output | 1 | Translated address valid |
| pci_miss | output | 1 | Offset outside the selected window |
| pci_addr | output | 32 | Translated PCI memory address |

## Verification
A mapping-register write and a translation through the same window can fall in the same cycle. The bench provokes this by driving a write to window 0's mapping register together with a hit on window 0. It then keeps the hit for two more cycles and checks that the first two results carry the old base and the third carries the new one. A second collision checked is simultaneous hits on several windows: priority must follow the lowest index even when that window misses and a higher one would not.

// File: rtl/pcimem_pkg.sv
`timescale 1ns/1ps
package pcimem_pkg;

    localparam int REG_AW = 8;

    typedef enum logic {
        RULE_NIBBLE = 1'b0,
        RULE_MASKED = 1'b1
    } rule_e;

    typedef enum logic [1:0] {
        GRP_WBASE = 2'd0,
        GRP_SMAP  = 2'd1,
        GRP_MISC  = 2'd2,
        GRP_NONE  = 2'd3
    } grp_e;

    typedef struct packed {
        logic       ok;
        grp_e       grp;
        logic [1:0] idx;
    } dec_t;

    typedef struct packed {
        logic        valid;
        logic        miss;
        logic [31:0] addr;
    } xlat_t;

    // Register decode: full aligned word only, page in addr[7:4], index in addr[3:2]
    function automatic dec_t reg_decode(logic [REG_AW-1:0] a, logic [3:0] be, int nwin);
        dec_t d;
        d.ok  = 1'b0;
        d.grp = GRP_NONE;
        d.idx = a[3:2];
        if (be == 4'hF && a[1:0] == 2'b00) begin
            case (a[7:4])
                4'h0: if (int'(a[3:2]) < nwin) begin d.ok = 1'b1; d.grp = GRP_WBASE; end
                4'h1: if (int'(a[3:2]) < nwin) begin d.ok = 1'b1; d.grp = GRP_SMAP;  end
                4'h2: if (a[3] == 1'b0)        begin d.ok = 1'b1; d.grp = GRP_MISC;  end
                default: ;
            endcase
        end
        return d;
    endfunction

    function automatic logic [31:0] calc_base(logic [31:0] map, rule_e r, logic [31:0] size);
        if (r == RULE_NIBBLE)
            return {map[3:0], 28'h0};
        return map & ~(size - 32'd1);
    endfunction

endpackage

// File: rtl/pcimem_regs.sv
`timescale 1ns/1ps
module pcimem_regs
    import pcimem_pkg::*;
#(
    parameter int NWIN = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_en,
    input  logic                      acc_wr,
    input  logic [REG_AW-1:0]         acc_addr,
    input  logic [3:0]                acc_be,
    input  logic [31:0]               acc_wdata,
    output logic [31:0]               rdata_o,
    output logic                      err_o,
    output logic [NWIN-1:0][31:0]     wmap_o
);

    logic [NWIN-1:0][31:0] wmap_q;
    logic [NWIN-1:0][31:0] smap_q;
    logic [1:0][31:0]      misc_q;
    dec_t                  dec;
    logic [31:0]           rd_val;

    assign dec    = reg_decode(acc_addr, acc_be, NWIN);
    assign wmap_o = wmap_q;

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (dec.grp == GRP_WBASE && int'(dec.idx) == i) rd_val = wmap_q[i];
            if (dec.grp == GRP_SMAP  && int'(dec.idx) == i) rd_val = smap_q[i];
        end
        if (dec.grp == GRP_MISC) rd_val = dec.idx[0] ? misc_q[1] : misc_q[0];
        if (!dec.ok) rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wmap_q  <= '0;
            smap_q  <= '0;
            misc_q  <= '0;
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            err_o <= acc_en && !dec.ok;
            if (acc_en && acc_wr && dec.ok) begin
                for (int i = 0; i < NWIN; i++) begin
                    if (dec.grp == GRP_WBASE && int'(dec.idx) == i) wmap_q[i] <= acc_wdata;
                    if (dec.grp == GRP_SMAP  && int'(dec.idx) == i) smap_q[i] <= acc_wdata;
                end
                if (dec.grp == GRP_MISC) misc_q[dec.idx[0]] <= acc_wdata;
            end
            if (acc_en && !acc_wr)
                rdata_o <= rd_val;
        end
    end

    // R6: a rejected access leaves the stored registers untouched
    p_bad_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (wmap_q == $past(wmap_q) && smap_q == $past(smap_q) && misc_q == $past(misc_q)));

    // R6: a rejected read returns zero
    p_bad_rd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (err_o && !$past(acc_wr)) |-> (rdata_o == 32'd0));

endmodule

// File: rtl/pcimem_win.sv
`timescale 1ns/1ps
module pcimem_win
    import pcimem_pkg::*;
#(
    parameter logic [31:0] SIZE_NIB = 32'h1000_0000,
    parameter logic [31:0] SIZE_MSK = 32'h0100_0000,
    parameter int          OFF_W    = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  rule_e            rule_i,
    input  logic [31:0]      map_i,
    input  logic [OFF_W-1:0] off_i,
    output xlat_t            res_o
);

    logic [31:0] base_q;
    logic [31:0] size_q;
    logic [31:0] size_sel;
    logic [31:0] off_ext;
    logic        in_range;

    assign size_sel = (rule_i == RULE_NIBBLE) ? SIZE_NIB : SIZE_MSK;
    assign off_ext  = 32'(off_i);
    assign in_range = off_ext < size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            size_q <= size_sel;
        end else begin
            base_q <= calc_base(map_i, rule_i, size_sel);
            size_q <= size_sel;
        end
    end

    always_comb begin
        res_o.valid = in_range;
        res_o.miss  = !in_range;
        res_o.addr  = in_range ? (base_q + off_ext) : 32'd0;
    end

    // R2: under the nibble rule the base carries only the top four address bits
    p_nib_align_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rule_i) == RULE_NIBBLE) |-> (base_q[27:0] == 28'd0));

    // R3: under the masked rule the base is aligned to the window size
    p_msk_align_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(rule_i) == RULE_MASKED) |-> ((base_q & (SIZE_MSK - 32'd1)) == 32'd0));

    // R7: base only moves one cycle after its inputs move
    p_base_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($stable(map_i) && $stable(rule_i)) |=> $stable(base_q));

endmodule

// File: rtl/pcimem_xlate.sv
`timescale 1ns/1ps
module pcimem_xlate
    import pcimem_pkg::*;
#(
    parameter int                 NWIN      = 3,
    parameter int                 OFF_W     = 28,
    parameter logic [NWIN*32-1:0] NIB_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
    parameter logic [NWIN*32-1:0] MSK_SIZES = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rule_sel,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic [NWIN-1:0]   win_hit,
    input  logic [OFF_W-1:0]  win_off,
    output logic              pci_valid,
    output logic              pci_miss,
    output logic [31:0]       pci_addr
);

    rule_e                 rule;
    logic [NWIN-1:0][31:0] wmap;
    xlat_t                 res [NWIN];
    xlat_t                 pick;
    xlat_t                 out_q;
    logic                  found;

    assign rule = rule_e'(rule_sel);

    pcimem_regs #(.NWIN(NWIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (reg_en),
        .acc_wr    (reg_wr),
        .acc_addr  (reg_addr),
        .acc_be    (reg_be),
        .acc_wdata (reg_wdata),
        .rdata_o   (reg_rdata),
        .err_o     (reg_err),
        .wmap_o    (wmap)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        pcimem_win #(
            .SIZE_NIB (NIB_SIZES[g*32 +: 32]),
            .SIZE_MSK (MSK_SIZES[g*32 +: 32]),
            .OFF_W    (OFF_W)
        ) u_win (
            .clk    (clk),
            .rst    (rst),
            .rule_i (rule),
            .map_i  (wmap[g]),
            .off_i  (win_off),
            .res_o  (res[g])
        );
    end

    // Lowest index wins
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            if (!found && win_hit[i]) begin
                pick  = res[i];
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        out_q <= '0;
        else if (found) out_q <= pick;
        else            out_q <= '0;
    end

    assign pci_valid = out_q.valid;
    assign pci_miss  = out_q.miss;
    assign pci_addr  = out_q.addr;

    // R4: valid and miss never together, a miss carries a zero address
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(pci_valid && pci_miss));
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
        pci_miss |-> (pci_addr == 32'd0));

    // R7: every hit yields exactly one registered verdict next cycle
    p_resp_r7: assert property (@(posedge clk) disable iff (rst)
        (|win_hit) |=> (pci_valid || pci_miss));

    // R8: no hit means a quiet output next cycle
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (win_hit == '0) |=> (!pci_valid && !pci_miss));

endmodule

// File: tb/sim_pcimem_xlate.sv
`timescale 1ns/1ps
module sim_pcimem_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rule_sel = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic [2:0]  win_hit = '0;
    logic [27:0] win_off = '0;
    logic        pci_valid;
    logic        pci_miss;
    logic [31:0] pci_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcimem_xlate u0 (
        .clk(clk), .rst(rst), .rule_sel(rule_sel),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .win_hit(win_hit), .win_off(win_off),
        .pci_valid(pci_valid), .pci_miss(pci_miss), .pci_addr(pci_addr)
    );

    typedef struct packed {
        logic        rule;
        logic [1:0]  win;
        logic [31:0] map;
        logic [27:0] off;
        logic        valid;
        logic        miss;
        logic [31:0] addr;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 32'h0000_0005, 28'h000_0100, 1'b1, 1'b0, 32'h5000_0100},
        '{1'b0, 2'd0, 32'hFFFF_FFFA, 28'hBFF_FFFF, 1'b1, 1'b0, 32'hABFF_FFFF},
        '{1'b0, 2'd0, 32'h0000_0003, 28'hC00_0000, 1'b0, 1'b1, 32'h0000_0000},
        '{1'b0, 2'd1, 32'h1234_5678, 28'hFFF_FFFF, 1'b1, 1'b0, 32'h8FFF_FFFF},
        '{1'b0, 2'd2, 32'h0000_000F, 28'h0AB_CDE0, 1'b1, 1'b0, 32'hF0AB_CDE0},
        '{1'b1, 2'd0, 32'h1234_5678, 28'h0FF_FFFF, 1'b1, 1'b0, 32'h12FF_FFFF},
        '{1'b1, 2'd0, 32'h0000_0007, 28'h100_0000, 1'b0, 1'b1, 32'h0000_0000},
        '{1'b1, 2'd1, 32'hDEAD_BEEF, 28'h000_0044, 1'b1, 1'b0, 32'hDC00_0044},
        '{1'b1, 2'd2, 32'hFFFF_FFFF, 28'h7FF_FFFF, 1'b1, 1'b0, 32'hFFFF_FFFF},
        '{1'b1, 2'd2, 32'h89AB_CDEF, 28'h000_0123, 1'b1, 1'b0, 32'h8800_0123}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_be = 4'hF;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata; e = reg_err;
    endtask

    task automatic xlate(input logic [2:0] hit, input logic [27:0] off,
                         output logic v, output logic m, output logic [31:0] a);
        @(negedge clk);
        win_hit = hit; win_off = off;
        @(negedge clk);
        win_hit = '0;
        v = pci_valid; m = pci_miss; a = pci_addr;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a;
        logic        e, v, m;

        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(pci_valid), 0);
        chk("R1 miss", 32'(pci_miss), 0);
        chk("R1 err", 32'(reg_err), 0);
        chk("R1 rdata", reg_rdata, 0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ra;
            ra = (i < 3) ? 8'(i*4) : (i < 6) ? 8'(8'h10 + (i-3)*4) : 8'(8'h20 + (i-6)*4);
            reg_read(ra, d, e);
            chk("R1 reg cleared", d, 0);
        end
        xlate(3'b010, 28'h123, v, m, a);
        chk("R1 zero base addr", a, 32'h0000_0123);
        chk("R1 zero base valid", 32'(v), 1);

        // R2 R3 R4 vector table
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            rule_sel = VECS[k].rule;
            reg_write(8'(VECS[k].win) << 2, VECS[k].map, 4'hF);
            repeat (2) @(negedge clk);
            xlate(3'b001 << VECS[k].win, VECS[k].off, v, m, a);
            chk(VECS[k].rule ? "R3 addr" : "R2 addr", a, VECS[k].addr);
            chk("R4 valid", 32'(v), 32'(VECS[k].valid));
            chk("R4 miss", 32'(m), 32'(VECS[k].miss));
        end

        // R5 register readback
        reg_write(8'h10, 32'hCAFE_F00D, 4'hF);
        reg_write(8'h14, 32'h0BAD_CAFE, 4'hF);
        reg_write(8'h18, 32'h1357_9BDF, 4'hF);
        reg_write(8'h20, 32'h1122_3344, 4'hF);
        reg_write(8'h24, 32'h0000_A5A5, 4'hF);
        reg_read(8'h10, d, e); chk("R5 smap0", d, 32'hCAFE_F00D); chk("R5 err", 32'(e), 0);
        reg_read(8'h14, d, e); chk("R5 smap1", d, 32'h0BAD_CAFE);
        reg_read(8'h18, d, e); chk("R5 smap2", d, 32'h1357_9BDF);
        reg_read(8'h20, d, e); chk("R5 ident", d, 32'h1122_3344);
        reg_read(8'h24, d, e); chk("R5 misc", d, 32'h0000_A5A5);
        reg_read(8'h08, d, e); chk("R5 map2 full word", d, 32'h89AB_CDEF);
        reg_read(8'h04, d, e); chk("R5 map1", d, 32'hDEAD_BEEF);

        // R6 illegal accesses
        reg_write(8'h0C, 32'hFFFF_FFFF, 4'hF);
        chk("R6 err hole write", 32'(reg_err), 1);
        reg_read(8'h0C, d, e);
        chk("R6 hole read data", d, 0); chk("R6 hole read err", 32'(e), 1);
        reg_write(8'h04, 32'h0000_0000, 4'h3);
        chk("R6 err partial", 32'(reg_err), 1);
        reg_read(8'h04, d, e);
        chk("R6 partial ignored", d, 32'hDEAD_BEEF);
        reg_write(8'h21, 32'h0, 4'hF);
        chk("R6 err misaligned", 32'(reg_err), 1);
        reg_read(8'h20, d, e);
        chk("R6 misaligned ignored", d, 32'h1122_3344);
        @(negedge clk);
        chk("R6 err one pulse", 32'(reg_err), 0);
        rule_sel = 1'b1;
        repeat (2) @(negedge clk);
        xlate(3'b010, 28'h44, v, m, a);
        chk("R6 window1 unchanged", a, 32'hDC00_0044);

        // R7 write and hit in the same cycle
        rule_sel = 1'b0;
        reg_write(8'h00, 32'h1, 4'hF);
        repeat (3) @(negedge clk);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h2;
        win_hit = 3'b001; win_off = 28'h10;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
        chk("R7 same-cycle old base", pci_addr, 32'h1000_0010);
        @(negedge clk);
        chk("R7 next-cycle old base", pci_addr, 32'h1000_0010);
        @(negedge clk);
        chk("R7 new base", pci_addr, 32'h2000_0010);
        win_hit = '0;
        @(negedge clk);
        chk("R7 hit released", 32'(pci_valid), 0);

        // R8 priority
        reg_write(8'h00, 32'h1, 4'hF);
        reg_write(8'h04, 32'h2, 4'hF);
        reg_write(8'h08, 32'h3, 4'hF);
        repeat (2) @(negedge clk);
        xlate(3'b110, 28'h5, v, m, a);
        chk("R8 w1 over w2", a, 32'h2000_0005);
        xlate(3'b111, 28'h5, v, m, a);
        chk("R8 w0 over all", a, 32'h1000_0005);
        xlate(3'b011, 28'hC00_0000, v, m, a);
        chk("R8 w0 miss wins", 32'(m), 1);
        chk("R8 w0 miss valid", 32'(v), 0);
        xlate(3'b000, 28'h5, v, m, a);
        chk("R8 none valid", 32'(v), 0);
        chk("R8 none miss", 32'(m), 0);

        // R1 mid-run reset clears
        do_reset();
        reg_read(8'h04, d, e);
        chk("R1 map cleared", d, 0);
        xlate(3'b100, 28'h77, v, m, a);
        chk("R1 base cleared", a, 32'h0000_0077);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule